// File: doc/BRIEF.md
# Prioritized Interrupt and Trap Controller

This block decides, once per instruction cycle, whether the processor must leave its current flow to serve a peripheral interrupt or a hard trap. Peripheral requests each carry an enable bit and a 3-bit programmable priority. Hard traps have fixed priorities above every peripheral request. The current processor level is a 4-bit value. Its lower three bits are the software-visible priority. Its top bit is set only while a trap is in service.

When a request wins, the block writes a two-word context frame to a stack memory that grows upward. The frame holds the program counter, the status flags and the old level. The block then raises the level and emits the handler's vector address. A return command reads the frame back in reverse order and restores the program counter, the flags and the level. A hard trap that arrives while a higher-priority trap is still open produces a device reset request and sets a sticky status bit.

Top module: `intc_ctrl`

## Requirements
- R1: On a `cyc_start` pulse, each peripheral request is sampled as pending only if both its flag and its enable bit are 1. A flag whose enable bit is 0 never causes an entry.
- R2: An entry starts only if the winning level is strictly greater than `cur_lvl`. A winner whose level is equal or lower is not taken. Peripheral level = {0, prio}.
- R3: Among pending peripheral requests, the highest priority wins. Equal priorities go to the lower request index.
- R4: On entry, two stack writes follow in consecutive cycles. The first write appears two cycles after the `cyc_start` cycle. Word 0 is PC[15:0] at the stack pointer. Word 1 is at the stack pointer plus 2 and holds {old level[2:0] in bits 15:13, flags in bits 12:8, old level bit 3 in bit 7, PC[22:16] in bits 6:0}. The stack pointer starts at 0x0800 after reset and advances by 2 per write.
- R5: In the cycle after the second write, `vec_valid` is high for exactly one cycle and `cur_lvl` becomes the accepted level. After reset, `cur_lvl` is 0 and no stack access takes place.
- R6: A `reti` pulse causes two reads: first at SP-2, then at SP-4, with the stack pointer moving down by 2 per read. Read data arrives one cycle after each read. `ret_valid` pulses three cycles after the `reti` cycle with the restored PC and flags. In that same cycle, `cur_lvl` returns to the saved level.
- R7: Trap t is pending from its request pulse until it is taken. It outranks every peripheral request and is served at level {1, 7-t}, so bit 3 of `cur_lvl` is set only while a trap is in service. Lower t means higher priority.
- R8: The vector address is 0x000004 + 2t for trap t and 0x000014 + 2i for peripheral request i. When `alt_table` is 1, 0x80 is added.
- R9: If trap t is requested while any trap of lower index is pending or in service, `reset_req` pulses in the next cycle and `trap_rst_flag` becomes 1 and stays 1 until `rst`. A higher-priority trap that arrives during a lower-priority one raises no reset request.
- R10: An `ipl_wr` pulse in an idle cycle sets `cur_lvl[2:0]` to `ipl_wdata`. If the level is lowered while a request flag is still set, the same request enters again on the next `cyc_start`, and its frame is stacked above the first one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_start | input | 1 | Instruction cycle boundary; samples requests |
| irq_flag | input | N_IRQ | Peripheral request flags |
| irq_en | input | N_IRQ | Peripheral request enables |
| irq_prio | input | 3*N_IRQ | Priority of request i in bits [3i+2:3i] |
| trap_req | input | N_TRAP | Hard trap request pulses, index 0 highest |
| alt_table | input | 1 | Selects the alternate vector table |
| pc_in | input | PC_W | Program counter to save on entry |
| sr_flags_in | input | FLG_W | Status flags to save on entry |
| ipl_wr | input | 1 | Software write of the priority level |
| ipl_wdata | input | 3 | Level value for a software write |
| reti | input | 1 | Return-from-interrupt command |
| stk_rdata | input | 16 | Stack read data, one cycle after a read |
| stk_we | output | 1 | Stack write strobe |
| stk_re | output | 1 | Stack read strobe |
| stk_addr | output | 16 | Stack byte address |
| stk_wdata | output | 16 | Stack write data |
| cur_lvl | output | 4 | Current level: trap bit and priority |
| vec_valid | output | 1 | Vector address valid pulse |
| vec_addr | output | 24 | Handler vector address |
| ret_valid | output | 1 | Return complete pulse |
| pc_restore | output | PC_W | Restored program counter |
| flags_restore | output | FLG_W | Restored status flags |
| reset_req | output | 1 | Device reset request pulse |
| trap_rst_flag | output | 1 | Sticky trap-conflict reset status |

## Verification
The bench checks a request whose priority equals the current level. A design that compared with greater-or-equal would re-enter its own handler. It checks equal-priority requests, where an arbiter with the tie going the wrong way would return the higher-index vector. It checks the exact bit placement of the second frame word, which a misordered push would scramble, and nested frames after a software level drop, where a wrong stack-pointer update would overwrite the first frame. It also checks a higher trap arriving inside a lower one, which must preempt without a reset, and the opposite order, which must reset and leave the sticky flag set.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int PRIO_W = 3;
  localparam int LVL_W  = PRIO_W + 1;
  localparam int WORD_W = 16;

  typedef enum logic [2:0] {
    S_IDLE,
    S_EVAL,
    S_PUSH1,
    S_VEC,
    S_POP1,
    S_POP2,
    S_POP3
  } seq_t;
endpackage

// File: rtl/intc_arbiter.sv
module intc_arbiter
  import intc_pkg::*;
#(
  parameter int N_IRQ  = 8,
  parameter int N_TRAP = 4,
  parameter int IDX_W  = 3
) (
  input  logic [N_IRQ-1:0]        irq_pend,
  input  logic [N_IRQ*PRIO_W-1:0] irq_prio,
  input  logic [N_TRAP-1:0]       trap_pend,
  output logic                    win_valid,
  output logic                    win_trap,
  output logic [IDX_W-1:0]        win_idx,
  output logic [LVL_W-1:0]        win_lvl
);
  // Scan from the top index down with >= so the lowest index wins a tie.
  always_comb begin
    win_valid = 1'b0;
    win_trap  = 1'b0;
    win_idx   = '0;
    win_lvl   = '0;
    for (int i = N_IRQ - 1; i >= 0; i--) begin
      if (irq_pend[i] && (irq_prio[i*PRIO_W +: PRIO_W] >= win_lvl[PRIO_W-1:0])) begin
        win_valid = 1'b1;
        win_idx   = IDX_W'(i);
        win_lvl   = {1'b0, irq_prio[i*PRIO_W +: PRIO_W]};
      end
    end
    // Any pending trap overrides; lowest trap index has the highest level.
    for (int t = N_TRAP - 1; t >= 0; t--) begin
      if (trap_pend[t]) begin
        win_valid = 1'b1;
        win_trap  = 1'b1;
        win_idx   = IDX_W'(t);
        win_lvl   = {1'b1, ~PRIO_W'(t)};
      end
    end
  end
endmodule

// File: rtl/intc_trap_mgr.sv
module intc_trap_mgr #(
  parameter int N_TRAP = 4,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_TRAP-1:0] trap_req,
  input  logic              take_trap,
  input  logic [IDX_W-1:0]  take_idx,
  input  logic              ret_trap,
  input  logic [IDX_W-1:0]  ret_idx,
  output logic [N_TRAP-1:0] trap_pend,
  output logic              reset_req,
  output logic              rst_flag
);
  logic [N_TRAP-1:0] svc, busy, conf, take_m, ret_m;

  assign busy   = trap_pend | svc;
  assign take_m = take_trap ? (N_TRAP'(1) << take_idx) : '0;
  assign ret_m  = ret_trap  ? (N_TRAP'(1) << ret_idx)  : '0;

  // A request conflicts when any stronger (lower index) trap is still open.
  for (genvar t = 0; t < N_TRAP; t++) begin : g_conf
    if (t == 0) begin : g_top
      assign conf[t] = 1'b0;
    end else begin : g_low
      assign conf[t] = trap_req[t] & (|busy[t-1:0]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      trap_pend <= '0;
      svc       <= '0;
      reset_req <= 1'b0;
      rst_flag  <= 1'b0;
    end else begin
      trap_pend <= (trap_pend | trap_req) & ~take_m;
      svc       <= (svc | take_m) & ~ret_m;
      reset_req <= |conf;
      if (|conf) rst_flag <= 1'b1;
    end
  end
endmodule

// File: rtl/intc_vector.sv
module intc_vector #(
  parameter int IDX_W     = 3,
  parameter int AW        = 24,
  parameter int TRAP_BASE = 'h04,
  parameter int IRQ_BASE  = 'h14,
  parameter int ALT_OFS   = 'h80
) (
  input  logic             is_trap,
  input  logic [IDX_W-1:0] idx,
  input  logic             alt,
  output logic [AW-1:0]    addr
);
  localparam logic [AW-1:0] TB = AW'(TRAP_BASE);
  localparam logic [AW-1:0] IB = AW'(IRQ_BASE);
  localparam logic [AW-1:0] AO = AW'(ALT_OFS);

  // Two bytes per table entry.
  assign addr = (is_trap ? TB : IB) + (AW'(idx) << 1) + (alt ? AO : '0);
endmodule

// File: rtl/intc_ctrl.sv
module intc_ctrl
  import intc_pkg::*;
#(
  parameter int N_IRQ     = 8,
  parameter int N_TRAP    = 4,
  parameter int PC_W      = 23,
  parameter int AW        = 24,
  parameter int SP_RESET  = 'h0800,
  parameter int TRAP_BASE = 'h04,
  parameter int IRQ_BASE  = 'h14,
  parameter int ALT_OFS   = 'h80,
  localparam int HI_W     = PC_W - WORD_W,
  localparam int FLG_W    = WORD_W - LVL_W - HI_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cyc_start,
  input  logic [N_IRQ-1:0]        irq_flag,
  input  logic [N_IRQ-1:0]        irq_en,
  input  logic [N_IRQ*PRIO_W-1:0] irq_prio,
  input  logic [N_TRAP-1:0]       trap_req,
  input  logic                    alt_table,
  input  logic [PC_W-1:0]         pc_in,
  input  logic [FLG_W-1:0]        sr_flags_in,
  input  logic                    ipl_wr,
  input  logic [PRIO_W-1:0]       ipl_wdata,
  input  logic                    reti,
  input  logic [WORD_W-1:0]       stk_rdata,
  output logic                    stk_we,
  output logic                    stk_re,
  output logic [WORD_W-1:0]       stk_addr,
  output logic [WORD_W-1:0]       stk_wdata,
  output logic [LVL_W-1:0]        cur_lvl,
  output logic                    vec_valid,
  output logic [AW-1:0]           vec_addr,
  output logic                    ret_valid,
  output logic [PC_W-1:0]         pc_restore,
  output logic [FLG_W-1:0]        flags_restore,
  output logic                    reset_req,
  output logic                    trap_rst_flag
);
  localparam int IDX_N = (N_IRQ > N_TRAP) ? N_IRQ : N_TRAP;
  localparam int IDX_W = (IDX_N > 1) ? $clog2(IDX_N) : 1;
  localparam logic [WORD_W-1:0] STEP = WORD_W'(WORD_W / 8);

  seq_t                    st;
  logic [WORD_W-1:0]       sp;
  logic [WORD_W-1:0]       hi_lat;
  logic [N_IRQ-1:0]        samp_irq;
  logic [N_IRQ*PRIO_W-1:0] samp_prio;
  logic [N_TRAP-1:0]       trap_pend;
  logic                    win_valid, win_trap;
  logic [IDX_W-1:0]        win_idx;
  logic [LVL_W-1:0]        win_lvl;
  logic                    sel_trap;
  logic [IDX_W-1:0]        sel_idx;
  logic [LVL_W-1:0]        sel_lvl;
  logic [HI_W-1:0]         pc_hi_lat;
  logic [FLG_W-1:0]        flg_lat;
  logic                    take, take_trap, ret_trap;
  logic [IDX_W-1:0]        ret_idx;
  logic [AW-1:0]           vec_calc;

  intc_arbiter #(.N_IRQ(N_IRQ), .N_TRAP(N_TRAP), .IDX_W(IDX_W)) u_arb (
    .irq_pend  (samp_irq),
    .irq_prio  (samp_prio),
    .trap_pend (trap_pend),
    .win_valid (win_valid),
    .win_trap  (win_trap),
    .win_idx   (win_idx),
    .win_lvl   (win_lvl)
  );

  // Strict comparison: an equal level never interrupts.
  assign take      = (st == S_EVAL) && win_valid && (win_lvl > cur_lvl);
  assign take_trap = take && win_trap;
  assign ret_trap  = (st == S_POP3) && cur_lvl[PRIO_W];
  assign ret_idx   = IDX_W'(~cur_lvl[PRIO_W-1:0]);

  intc_trap_mgr #(.N_TRAP(N_TRAP), .IDX_W(IDX_W)) u_trap (
    .clk       (clk),
    .rst       (rst),
    .trap_req  (trap_req),
    .take_trap (take_trap),
    .take_idx  (win_idx),
    .ret_trap  (ret_trap),
    .ret_idx   (ret_idx),
    .trap_pend (trap_pend),
    .reset_req (reset_req),
    .rst_flag  (trap_rst_flag)
  );

  intc_vector #(
    .IDX_W(IDX_W), .AW(AW), .TRAP_BASE(TRAP_BASE),
    .IRQ_BASE(IRQ_BASE), .ALT_OFS(ALT_OFS)
  ) u_vec (
    .is_trap (sel_trap),
    .idx     (sel_idx),
    .alt     (alt_table),
    .addr    (vec_calc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st            <= S_IDLE;
      sp            <= WORD_W'(SP_RESET);
      hi_lat        <= '0;
      samp_irq      <= '0;
      samp_prio     <= '0;
      sel_trap      <= 1'b0;
      sel_idx       <= '0;
      sel_lvl       <= '0;
      pc_hi_lat     <= '0;
      flg_lat       <= '0;
      stk_we        <= 1'b0;
      stk_re        <= 1'b0;
      stk_addr      <= '0;
      stk_wdata     <= '0;
      cur_lvl       <= '0;
      vec_valid     <= 1'b0;
      vec_addr      <= '0;
      ret_valid     <= 1'b0;
      pc_restore    <= '0;
      flags_restore <= '0;
    end else begin
      stk_we    <= 1'b0;
      stk_re    <= 1'b0;
      vec_valid <= 1'b0;
      ret_valid <= 1'b0;
      case (st)
        S_IDLE: begin
          if (cyc_start) begin
            samp_irq  <= irq_flag & irq_en;
            samp_prio <= irq_prio;
            st        <= S_EVAL;
          end else if (reti) begin
            // Pre-decrement: frame word 1 is read first.
            stk_re   <= 1'b1;
            stk_addr <= sp - STEP;
            sp       <= sp - STEP;
            st       <= S_POP1;
          end else if (ipl_wr) begin
            cur_lvl[PRIO_W-1:0] <= ipl_wdata;
          end
        end
        S_EVAL: begin
          if (take) begin
            sel_trap  <= win_trap;
            sel_idx   <= win_idx;
            sel_lvl   <= win_lvl;
            pc_hi_lat <= pc_in[PC_W-1:WORD_W];
            flg_lat   <= sr_flags_in;
            stk_we    <= 1'b1;
            stk_addr  <= sp;
            stk_wdata <= pc_in[WORD_W-1:0];
            sp        <= sp + STEP;
            st        <= S_PUSH1;
          end else begin
            st <= S_IDLE;
          end
        end
        S_PUSH1: begin
          stk_we    <= 1'b1;
          stk_addr  <= sp;
          stk_wdata <= {cur_lvl[PRIO_W-1:0], flg_lat, cur_lvl[PRIO_W], pc_hi_lat};
          sp        <= sp + STEP;
          st        <= S_VEC;
        end
        S_VEC: begin
          cur_lvl   <= sel_lvl;
          vec_valid <= 1'b1;
          vec_addr  <= vec_calc;
          st        <= S_IDLE;
        end
        S_POP1: begin
          stk_re   <= 1'b1;
          stk_addr <= sp - STEP;
          sp       <= sp - STEP;
          st       <= S_POP2;
        end
        S_POP2: begin
          hi_lat <= stk_rdata;
          st     <= S_POP3;
        end
        S_POP3: begin
          pc_restore    <= {hi_lat[HI_W-1:0], stk_rdata};
          flags_restore <= hi_lat[HI_W+1 +: FLG_W];
          cur_lvl       <= {hi_lat[HI_W], hi_lat[WORD_W-1 -: PRIO_W]};
          ret_valid     <= 1'b1;
          st            <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/intc_ctrl_chk.sv
module intc_ctrl_chk (
  input logic        clk,
  input logic        rst,
  input logic        stk_we,
  input logic        stk_re,
  input logic [15:0] stk_addr,
  input logic [3:0]  cur_lvl,
  input logic        vec_valid,
  input logic [23:0] vec_addr,
  input logic        ret_valid,
  input logic        reset_req,
  input logic        trap_rst_flag
);
  AST_PUSH_ASCENDS: assert property (@(posedge clk) disable iff (rst)
    $rose(stk_we) |=> stk_we && (stk_addr == $past(stk_addr) + 16'd2));  // R4
  AST_POP_DESCENDS: assert property (@(posedge clk) disable iff (rst)
    $rose(stk_re) |=> stk_re && (stk_addr == $past(stk_addr) - 16'd2));  // R6
  AST_NO_RW_OVERLAP: assert property (@(posedge clk) disable iff (rst)
    !(stk_we && stk_re));  // R4
  AST_LEVEL_RISES: assert property (@(posedge clk) disable iff (rst)
    $rose(vec_valid) |-> (cur_lvl > $past(cur_lvl)));  // R2
  AST_VEC_SINGLE: assert property (@(posedge clk) disable iff (rst)
    vec_valid |=> !vec_valid);  // R5
  AST_RET_SINGLE: assert property (@(posedge clk) disable iff (rst)
    ret_valid |=> !ret_valid);  // R6
  AST_TRAP_SETS_BIT: assert property (@(posedge clk) disable iff (rst)
    (vec_valid && ((vec_addr & ~24'h80) < 24'h14)) |-> cur_lvl[3]);  // R7
  AST_IRQ_CLEARS_BIT: assert property (@(posedge clk) disable iff (rst)
    (vec_valid && ((vec_addr & ~24'h80) >= 24'h14)) |-> !cur_lvl[3]);  // R7
  AST_RESET_FLAGGED: assert property (@(posedge clk) disable iff (rst)
    reset_req |-> trap_rst_flag);  // R9
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    trap_rst_flag |=> trap_rst_flag);  // R9
endmodule

bind intc_ctrl intc_ctrl_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .stk_we        (stk_we),
  .stk_re        (stk_re),
  .stk_addr      (stk_addr),
  .cur_lvl       (cur_lvl),
  .vec_valid     (vec_valid),
  .vec_addr      (vec_addr),
  .ret_valid     (ret_valid),
  .reset_req     (reset_req),
  .trap_rst_flag (trap_rst_flag)
);

// File: tb/tb_intc_ctrl.sv
module tb_intc_ctrl;
  localparam int N_IRQ = 8;
  localparam int N_TRAP = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cyc_start = 1'b0;
  logic [7:0]  irq_flag = '0;
  logic [7:0]  irq_en = '0;
  logic [23:0] irq_prio = '0;
  logic [3:0]  trap_req = '0;
  logic        alt_table = 1'b0;
  logic [22:0] pc_in = '0;
  logic [4:0]  sr_flags_in = '0;
  logic        ipl_wr = 1'b0;
  logic [2:0]  ipl_wdata = '0;
  logic        reti = 1'b0;
  logic [15:0] stk_rdata = '0;
  logic        stk_we, stk_re;
  logic [15:0] stk_addr, stk_wdata;
  logic [3:0]  cur_lvl;
  logic        vec_valid, ret_valid, reset_req, trap_rst_flag;
  logic [23:0] vec_addr;
  logic [22:0] pc_restore;
  logic [4:0]  flags_restore;

  int ntests = 0;
  int nfail = 0;
  logic [15:0] mem [64];

  always #2 clk = ~clk;

  intc_ctrl #(.N_IRQ(N_IRQ), .N_TRAP(N_TRAP)) dut (
    .clk(clk), .rst(rst), .cyc_start(cyc_start), .irq_flag(irq_flag),
    .irq_en(irq_en), .irq_prio(irq_prio), .trap_req(trap_req),
    .alt_table(alt_table), .pc_in(pc_in), .sr_flags_in(sr_flags_in),
    .ipl_wr(ipl_wr), .ipl_wdata(ipl_wdata), .reti(reti),
    .stk_rdata(stk_rdata), .stk_we(stk_we), .stk_re(stk_re),
    .stk_addr(stk_addr), .stk_wdata(stk_wdata), .cur_lvl(cur_lvl),
    .vec_valid(vec_valid), .vec_addr(vec_addr), .ret_valid(ret_valid),
    .pc_restore(pc_restore), .flags_restore(flags_restore),
    .reset_req(reset_req), .trap_rst_flag(trap_rst_flag)
  );

  // Stack memory: one-cycle read latency.
  always @(posedge clk) begin
    if (stk_we) mem[stk_addr[6:1]] <= stk_wdata;
    if (stk_re) stk_rdata <= mem[stk_addr[6:1]];
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    ntests++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] frame_hi(input logic [2:0] lv, input logic [4:0] fl,
                                           input logic tb, input logic [6:0] pch);
    return {lv, fl, tb, pch};
  endfunction

  function automatic logic [23:0] set_prio(input logic [23:0] cur, input int i,
                                           input logic [2:0] p);
    logic [23:0] r = cur;
    r[i*3 +: 3] = p;
    return r;
  endfunction

  // Pulse cyc_start and watch the following six cycles.
  task automatic run_cs(output int n_we, output logic [15:0] a0, output logic [15:0] d0,
                        output logic [15:0] a1, output logic [15:0] d1, output int we_k,
                        output logic [23:0] va, output int vec_k, output int vec_cnt);
    n_we = 0; vec_cnt = 0; we_k = -1; vec_k = -1;
    a0 = '0; d0 = '0; a1 = '0; d1 = '0; va = '0;
    @(negedge clk) cyc_start = 1'b1;
    @(negedge clk) cyc_start = 1'b0;
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      if (stk_we) begin
        if (n_we == 0) begin a0 = stk_addr; d0 = stk_wdata; we_k = k; end
        else if (n_we == 1) begin a1 = stk_addr; d1 = stk_wdata; end
        n_we++;
      end
      if (vec_valid) begin
        if (vec_cnt == 0) begin va = vec_addr; vec_k = k; end
        vec_cnt++;
      end
    end
  endtask

  task automatic run_ret(output int k_ret, output logic [22:0] pc, output logic [4:0] fl);
    k_ret = -1; pc = '0; fl = '0;
    @(negedge clk) reti = 1'b1;
    @(negedge clk) reti = 1'b0;
    for (int k = 1; k <= 5; k++) begin
      @(negedge clk);
      if (ret_valid && k_ret < 0) begin k_ret = k; pc = pc_restore; fl = flags_restore; end
    end
  endtask

  task automatic sw_level(input logic [2:0] v);
    @(negedge clk) begin ipl_wr = 1'b1; ipl_wdata = v; end
    @(negedge clk) ipl_wr = 1'b0;
  endtask

  task automatic pulse_trap(input int t);
    @(negedge clk) trap_req[t] = 1'b1;
    @(negedge clk) trap_req = '0;
  endtask

  task automatic t_reset;
    check(cur_lvl == 4'h0, "R5 reset level", 32'(cur_lvl), 0);
    check(!stk_we && !stk_re && !vec_valid && !reset_req && !trap_rst_flag,
          "R5 reset outputs idle", {stk_we, stk_re, vec_valid, reset_req, trap_rst_flag}, 0);
  endtask

  task automatic t_masked;
    int n, wk, vk, vc; logic [15:0] a0, d0, a1, d1; logic [23:0] va;
    irq_flag[3] = 1'b1; irq_en[3] = 1'b0; irq_prio = set_prio(irq_prio, 3, 3'd5);
    run_cs(n, a0, d0, a1, d1, wk, va, vk, vc);
    check(n == 0 && vc == 0, "R1 disabled flag ignored", 32'(n + vc), 0);
    check(cur_lvl == 4'h0, "R1 level unchanged", 32'(cur_lvl), 0);
  endtask

  task automatic t_enter;
    int n, wk, vk, vc; logic [15:0] a0, d0, a1, d1; logic [23:0] va;
    irq_en[3] = 1'b1; pc_in = 23'h4A1234; sr_flags_in = 5'h15;
    run_cs(n, a0, d0, a1, d1, wk, va, vk, vc);
    check(n == 2 && wk == 1, "R4 two writes, first two cycles after start", 32'(wk), 1);
    check(a0 == 16'h0800 && d0 == 16'h1234, "R4 word0", {a0, d0}, 32'h08001234);
    check(a1 == 16'h0802 && d1 == frame_hi(3'd0, 5'h15, 1'b0, 7'h4A), "R4 word1",
          {a1, d1}, {16'h0802, frame_hi(3'd0, 5'h15, 1'b0, 7'h4A)});
    check(vk == 3 && vc == 1, "R5 single vector pulse after push", 32'(vk), 3);
    check(va == 24'h00001A, "R8 vector irq3", va, 24'h1A);
    check(cur_lvl == 4'h5, "R5 level raised", 32'(cur_lvl), 5);
    irq_flag[3] = 1'b0;
  endtask

  task automatic t_not_higher;
    int n, wk, vk, vc; logic [15:0] a0, d0, a1, d1; logic [23:0] va;
    irq_flag[1] = 1'b1; irq_en[1] = 1'b1; irq_prio = set_prio(irq_prio, 1, 3'd5);
    run_cs(n, a0, d0, a1, d1, wk, va, vk, vc);
    check(n == 0 && vc == 0, "R2 equal level not taken", 32'(n + vc), 0);
    irq_prio = set_prio(irq_prio, 1, 3'd4);
    run_cs(n, a0, d0, a1, d1, wk, va, vk, vc);
    check(n == 0 && vc == 0, "R2 lower level not taken", 32'(n + vc), 0);
    irq_flag[1] = 1'b0;
  endtask

  task automatic t_return;
    int kr; logic [22:0] pc; logic [4:0] fl;
    run_ret(kr, pc, fl);
    check(kr == 3, "R6 return timing", 32'(kr), 3);
    check(pc == 23'h4A1234 && fl == 5'h15, "R6 pc and flags restored", {4'h0, pc, fl},
          {4'h0, 23'h4A1234, 5'h15});
    check(cur_lvl == 4'h0, "R6 level restored", 32'(cur_lvl), 0);
  endtask

  task automatic t_arbitrate;
    int n, wk, vk, vc, kr; logic [15:0] a0, d0, a1, d1; logic [23:0] va;
    logic [22:0] pc; logic [4:0] fl;
    irq_en = 8'hFF; irq_prio = '0;
    irq_prio = set_prio(irq_prio, 2, 3'd3);
    irq_prio = set_prio(irq_prio, 5, 3'd6);
    irq_prio = set_prio(irq_prio, 6, 3'd6);
    irq_flag = 8'b0110_0100;
    run_cs(n, a0, d0, a1, d1, wk, va, vk, vc);
    check(va == 24'h1E && cur_lvl == 4'h6, "R3 highest priority, lower index on tie",
          {va[7:0], 20'h0, cur_lvl}, {8'h1E, 20'h0, 4'h6});
    check(a0 == 16'h0800, "R6 stack pointer restored by return", 32'(a0), 32'h0800);
    irq_flag = '0;
    run_ret(kr, pc, fl);
    irq_prio = set_prio(irq_prio, 2, 3'd4);
    irq_prio = set_prio(irq_prio, 6, 3'd4);
    irq_flag = 8'b0100_0100;
    run_cs(n, a0, d0, a1, d1, wk, va, vk, vc);
    check(va == 24'h18 && cur_lvl == 4'h4, "R3 tie goes to lower index",
          {va[7:0], 20'h0, cur_lvl}, {8'h18, 20'h0, 4'h4});
    irq_flag = '0;
    run_ret(kr, pc, fl);
  endtask

  task automatic t_alt;
    int n, wk, vk, vc, kr; logic [15:0] a0, d0, a1, d1; logic [23:0] va;
    logic [22:0] pc; logic [4:0] fl;
    alt_table = 1'b1; irq_prio = set_prio(irq_prio, 0, 3'd1); irq_flag = 8'h01;
    run_cs(n, a0, d0, a1, d1, wk, va, vk, vc);
    check(va == 24'h94, "R8 alternate table offset", va, 24'h94);
    irq_flag = '0;
    run_ret(kr, pc, fl);
    alt_table = 1'b0;
  endtask

  task automatic t_sw_lower;
    int n, wk, vk, vc, kr; logic [15:0] a0, d0, a1, d1; logic [23:0] va;
    logic [22:0] pc; logic [4:0] fl;
    sw_level(3'd1);
    check(cur_lvl == 4'h1, "R10 software level write", 32'(cur_lvl), 1);
    pc_in = 23'h000100; sr_flags_in = 5'h03;
    irq_prio = set_prio(irq_prio, 4, 3'd2); irq_flag = 8'h10;
    run_cs(n, a0, d0, a1, d1, wk, va, vk, vc);
    check(va == 24'h1C && cur_lvl == 4'h2, "R10 first entry", {va[7:0], 20'h0, cur_lvl},
          {8'h1C, 20'h0, 4'h2});
    sw_level(3'd0);
    check(cur_lvl == 4'h0, "R10 level lowered in handler", 32'(cur_lvl), 0);
    pc_in = 23'h000200;
    run_cs(n, a0, d0, a1, d1, wk, va, vk, vc);
    check(vc == 1 && a0 == 16'h0804, "R10 flag still set re-enters above first frame",
          {16'(vc), a0}, {16'd1, 16'h0804});
    check(d1 == frame_hi(3'd0, 5'h03, 1'b0, 7'h00), "R10 nested frame saved level", d1,
          frame_hi(3'd0, 5'h03, 1'b0, 7'h00));
    irq_flag = '0;
    run_ret(kr, pc, fl);
    check(pc == 23'h000200 && cur_lvl == 4'h0, "R6 inner return", {pc, 5'h0, cur_lvl},
          {23'h000200, 5'h0, 4'h0});
    run_ret(kr, pc, fl);
    check(pc == 23'h000100 && cur_lvl == 4'h1, "R6 outer return", {pc, 5'h0, cur_lvl},
          {23'h000100, 5'h0, 4'h1});
    sw_level(3'd0);
  endtask

  task automatic t_traps;
    int n, wk, vk, vc, kr; logic [15:0] a0, d0, a1, d1; logic [23:0] va;
    logic [22:0] pc; logic [4:0] fl;
    sw_level(3'd7);
    irq_prio = set_prio(irq_prio, 7, 3'd7); irq_flag = 8'h80;
    pc_in = 23'h7F0002; sr_flags_in = 5'h0A;
    pulse_trap(1);
    run_cs(n, a0, d0, a1, d1, wk, va, vk, vc);
    check(va == 24'h06 && cur_lvl == 4'hE, "R7 trap taken above level 7",
          {va[7:0], 20'h0, cur_lvl}, {8'h06, 20'h0, 4'hE});
    check(d1 == frame_hi(3'd7, 5'h0A, 1'b0, 7'h7F), "R7 frame keeps trap bit clear", d1,
          frame_hi(3'd7, 5'h0A, 1'b0, 7'h7F));
    pulse_trap(0);
    check(!reset_req, "R9 higher trap inside lower is no conflict", 32'(reset_req), 0);
    run_cs(n, a0, d0, a1, d1, wk, va, vk, vc);
    check(va == 24'h04 && cur_lvl == 4'hF, "R7 higher trap preempts",
          {va[7:0], 20'h0, cur_lvl}, {8'h04, 20'h0, 4'hF});
    check(d1[7] == 1'b1 && d1[15:13] == 3'd6, "R7 nested frame saves trap bit",
          32'(d1), 32'(frame_hi(3'd6, 5'h0A, 1'b1, 7'h7F)));
    run_ret(kr, pc, fl);
    check(cur_lvl == 4'hE, "R7 return to outer trap", 32'(cur_lvl), 32'hE);
    run_ret(kr, pc, fl);
    check(cur_lvl == 4'h7, "R7 trap bit cleared on return", 32'(cur_lvl), 7);
    check(!trap_rst_flag, "R9 no flag without conflict", 32'(trap_rst_flag), 0);
    irq_flag = '0;
    sw_level(3'd0);
  endtask

  task automatic t_conflict;
    pulse_trap(0);
    @(negedge clk) trap_req[2] = 1'b1;
    @(negedge clk) trap_req = '0;
    check(reset_req && trap_rst_flag, "R9 lower trap while higher pending resets",
          {reset_req, trap_rst_flag}, 2'b11);
    repeat (3) @(negedge clk);
    check(!reset_req && trap_rst_flag, "R9 reset pulse ends, flag sticky",
          {reset_req, trap_rst_flag}, 2'b01);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_masked();
    t_enter();
    t_not_higher();
    t_return();
    t_arbitrate();
    t_alt();
    t_sw_lower();
    t_traps();
    t_conflict();
    $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    ntests++;
    nfail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end
endmodule